// File: doc/BRIEF.md
# Multicycle Operand Fetch Sequencer

This block is the control unit and register datapath that brings an instruction and its operand into an accumulator-style processor. A request on `start` makes it copy the program counter into the memory address register and read the instruction word from a single-port memory. The word passes through the buffer register into the instruction register, and the program counter advances by one while the fetch read is under way. The instruction register's mode field then selects one of eight addressing paths. Each path differs in whether it uses the adder, whether it reads the register file, and how many further memory reads it makes.

The operand always comes out of the memory buffer register. Immediate and register operands are loaded there directly, and memory operands arrive there from the data bus. A one-cycle `operand_valid` pulse hands the value to the execute stage. Mode codes outside the legal set raise a one-cycle `illegal_mode` flag and return the sequencer to idle without any operand access. Memory reads use a hold-until-ready handshake, so any number of wait states is tolerated.

Top module: `opfetch_seq`

## Requirements
- R1: After reset the program counter is 0, and `mem_rd`, `operand_valid` and `illegal_mode` are low. With `start` low the block stays idle.
- R2: In idle, `start` loads MAR from the PC and issues one instruction read. On the accepted read the PC increases by exactly 1, and IR is then loaded from MBR. Instruction fields: mode in bits [15:12], register select in [11:10], address field in [7:0].
- R3: Mode 0 (immediate): the operand is the 8-bit address field zero-extended to 16 bits. Only the instruction read is made.
- R4: Mode 1 (register): `reg_sel` carries the IR register select and the operand is `reg_rdata`. Only the instruction read is made.
- R5: Mode 2 (direct) reads the operand at the address field. Mode 3 (register indirect) reads it at the low 8 bits of the selected register. Each makes one operand read.
- R6: Mode 4 (memory indirect) first reads at the address field. It then reads the operand at the low 8 bits of that word, for two operand reads in total.
- R7: Mode 5 (relative) reads the operand at the already incremented PC plus the address field, modulo 256. The adder request is raised.
- R8: Mode 6 (base) and mode 7 (indexed) both read the operand at the low 8 bits of the selected register plus the address field, modulo 256. The adder request is raised.
- R9: Each read holds `mem_rd` with a stable address until `mem_ready` is high. MBR loads only in that cycle, and each wait cycle delays completion by one cycle.
- R10: `operand_valid` lasts one cycle. With no wait states it comes 3 cycles after the `start` edge for modes 0 and 1, 4 cycles for modes 2, 3, 5, 6 and 7, and 6 cycles for mode 4.
- R11: Mode codes 8 to 15 raise `illegal_mode` for one cycle, 2 cycles after `start` with no wait states. No operand access follows, no `operand_valid` is given, and the block returns to idle.
- R12: `start` asserted while an instruction is in progress is ignored. The PC still moves by one for that instruction and its result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin fetching the next instruction |
| mem_rdata | input | 16 | Memory read data |
| mem_ready | input | 1 | Memory read data valid this cycle |
| reg_rdata | input | 16 | Register file read data for `reg_sel` |
| mem_addr | output | 8 | Memory address (MAR contents) |
| mem_rd | output | 1 | Memory read strobe |
| reg_sel | output | 2 | Register file index from IR |
| mar_sel | output | 3 | MAR source select this cycle |
| mar_ld | output | 1 | MAR load enable |
| mbr_ld | output | 1 | MBR load enable |
| ir_ld | output | 1 | IR load enable |
| pc_inc | output | 1 | PC increment enable |
| alu_add | output | 1 | Adder request for address computation |
| pc | output | 8 | Program counter |
| operand_valid | output | 1 | Operand available on `operand` |
| operand | output | 16 | Fetched operand (MBR contents) |
| illegal_mode | output | 1 | Unrecognised mode code seen |

## Verification
The hardest case to reach is a memory-indirect fetch with wait states. Three separate reads are each stretched, and the pointer returned by the first read must steer the last one. A wrong MBR capture on a non-ready cycle would then fetch from an unrelated address. The vector table pairs every mode with several wait-state counts through a latency-programmable memory model. Memory contents are a known function of the address, so each pointer lands at a distinct computable location. Wrap-around of the adder and the start-while-busy case are added as directed tests.

// File: rtl/opf_pkg.sv
package opf_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_FETCH, ST_IRLD, ST_DECODE, ST_INDRD, ST_INDMV, ST_OPRD, ST_DONE
   } opf_state_e;

   typedef enum logic [2:0] {
      MS_PC, MS_IR, MS_REG, MS_MBR, MS_PCREL, MS_REGREL
   } mar_src_e;

   typedef enum logic [1:0] {
      MB_MEM, MB_IMM, MB_REG
   } mbr_src_e;

   localparam int unsigned MD_IMM  = 0;
   localparam int unsigned MD_REG  = 1;
   localparam int unsigned MD_DIR  = 2;
   localparam int unsigned MD_RIND = 3;
   localparam int unsigned MD_MIND = 4;
   localparam int unsigned MD_REL  = 5;
   localparam int unsigned MD_BASE = 6;
   localparam int unsigned MD_IDX  = 7;
endpackage

// File: rtl/opf_datapath.sv
module opf_datapath
   import opf_pkg::*;
#(
   parameter int unsigned DW         = 16,
   parameter int unsigned AW         = 8,
   parameter int unsigned MODE_W     = 4,
   parameter int unsigned RSEL_W     = 2,
   parameter bit          IMM_SIGNED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DW-1:0]     mem_rdata,
   input  logic [DW-1:0]     reg_rdata,
   input  logic              mar_ld,
   input  mar_src_e          mar_sel,
   input  logic              mbr_ld,
   input  mbr_src_e          mbr_sel,
   input  logic              ir_ld,
   input  logic              pc_inc,
   output logic [AW-1:0]     pc_q,
   output logic [AW-1:0]     mar_q,
   output logic [DW-1:0]     mbr_q,
   output logic [MODE_W-1:0] ir_mode,
   output logic [RSEL_W-1:0] ir_rsel
);
   localparam int unsigned MODE_LSB = DW - MODE_W;
   localparam int unsigned RSEL_LSB = MODE_LSB - RSEL_W;

   logic [DW-1:0] ir_q;
   logic [AW-1:0] ir_addr;
   logic [AW-1:0] sum_base;
   logic [AW-1:0] addr_sum;
   logic [AW-1:0] mar_d;
   logic [DW-1:0] mbr_d;
   logic [DW-1:0] imm_ext;
   logic          unused_ir_bits;

   assign ir_mode        = ir_q[MODE_LSB +: MODE_W];
   assign ir_rsel        = ir_q[RSEL_LSB +: RSEL_W];
   assign ir_addr        = ir_q[AW-1:0];
   assign unused_ir_bits = ^ir_q;

   generate
      if (IMM_SIGNED) begin : g_imm_sx
         assign imm_ext = {{(DW-AW){ir_addr[AW-1]}}, ir_addr};
      end else begin : g_imm_zx
         assign imm_ext = {{(DW-AW){1'b0}}, ir_addr};
      end
   endgenerate

   assign sum_base = (mar_sel == MS_PCREL) ? pc_q : reg_rdata[AW-1:0];
   assign addr_sum = sum_base + ir_addr;

   always_comb begin
      case (mar_sel)
         MS_PC:     mar_d = pc_q;
         MS_IR:     mar_d = ir_addr;
         MS_REG:    mar_d = reg_rdata[AW-1:0];
         MS_MBR:    mar_d = mbr_q[AW-1:0];
         default:   mar_d = addr_sum;
      endcase
   end

   always_comb begin
      case (mbr_sel)
         MB_IMM:  mbr_d = imm_ext;
         MB_REG:  mbr_d = reg_rdata;
         default: mbr_d = mem_rdata;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q  <= '0;
         mar_q <= '0;
         mbr_q <= '0;
         ir_q  <= '0;
      end else begin
         if (pc_inc) pc_q  <= pc_q + 1'b1;
         if (mar_ld) mar_q <= mar_d;
         if (mbr_ld) mbr_q <= mbr_d;
         if (ir_ld)  ir_q  <= mbr_q;
      end
   end
endmodule

// File: rtl/opf_ctrl.sv
module opf_ctrl
   import opf_pkg::*;
#(
   parameter int unsigned MODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mem_ready,
   input  logic [MODE_W-1:0] ir_mode,
   output logic              mem_rd,
   output logic              mar_ld,
   output mar_src_e          mar_sel,
   output logic              mbr_ld,
   output mbr_src_e          mbr_sel,
   output logic              ir_ld,
   output logic              pc_inc,
   output logic              alu_add,
   output logic              operand_valid,
   output logic              illegal_mode
);
   opf_state_e state_q, state_d;

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d       = state_q;
      mem_rd        = 1'b0;
      mar_ld        = 1'b0;
      mar_sel       = MS_PC;
      mbr_ld        = 1'b0;
      mbr_sel       = MB_MEM;
      ir_ld         = 1'b0;
      pc_inc        = 1'b0;
      alu_add       = 1'b0;
      operand_valid = 1'b0;
      illegal_mode  = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (start) begin
               mar_ld  = 1'b1;
               state_d = ST_FETCH;
            end
         end
         ST_FETCH: begin
            mem_rd = 1'b1;
            if (mem_ready) begin
               mbr_ld  = 1'b1;
               pc_inc  = 1'b1;
               state_d = ST_IRLD;
            end
         end
         ST_IRLD: begin
            ir_ld   = 1'b1;
            state_d = ST_DECODE;
         end
         ST_DECODE: begin
            case (ir_mode)
               MODE_W'(MD_IMM): begin
                  mbr_ld = 1'b1; mbr_sel = MB_IMM; state_d = ST_DONE;
               end
               MODE_W'(MD_REG): begin
                  mbr_ld = 1'b1; mbr_sel = MB_REG; state_d = ST_DONE;
               end
               MODE_W'(MD_DIR): begin
                  mar_ld = 1'b1; mar_sel = MS_IR; state_d = ST_OPRD;
               end
               MODE_W'(MD_RIND): begin
                  mar_ld = 1'b1; mar_sel = MS_REG; state_d = ST_OPRD;
               end
               MODE_W'(MD_MIND): begin
                  mar_ld = 1'b1; mar_sel = MS_IR; state_d = ST_INDRD;
               end
               MODE_W'(MD_REL): begin
                  mar_ld = 1'b1; mar_sel = MS_PCREL; alu_add = 1'b1;
                  state_d = ST_OPRD;
               end
               MODE_W'(MD_BASE), MODE_W'(MD_IDX): begin
                  mar_ld = 1'b1; mar_sel = MS_REGREL; alu_add = 1'b1;
                  state_d = ST_OPRD;
               end
               default: begin
                  illegal_mode = 1'b1;
                  state_d      = ST_IDLE;
               end
            endcase
         end
         ST_INDRD: begin
            mem_rd = 1'b1;
            if (mem_ready) begin
               mbr_ld  = 1'b1;
               state_d = ST_INDMV;
            end
         end
         ST_INDMV: begin
            mar_ld  = 1'b1;
            mar_sel = MS_MBR;
            state_d = ST_OPRD;
         end
         ST_OPRD: begin
            mem_rd = 1'b1;
            if (mem_ready) begin
               mbr_ld  = 1'b1;
               state_d = ST_DONE;
            end
         end
         ST_DONE: begin
            operand_valid = 1'b1;
            state_d       = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end
endmodule

// File: rtl/opfetch_seq.sv
module opfetch_seq
   import opf_pkg::*;
#(
   parameter int unsigned DW         = 16,
   parameter int unsigned AW         = 8,
   parameter int unsigned MODE_W     = 4,
   parameter int unsigned RSEL_W     = 2,
   parameter bit          IMM_SIGNED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DW-1:0]     mem_rdata,
   input  logic              mem_ready,
   input  logic [DW-1:0]     reg_rdata,
   output logic [AW-1:0]     mem_addr,
   output logic              mem_rd,
   output logic [RSEL_W-1:0] reg_sel,
   output logic [2:0]        mar_sel,
   output logic              mar_ld,
   output logic              mbr_ld,
   output logic              ir_ld,
   output logic              pc_inc,
   output logic              alu_add,
   output logic [AW-1:0]     pc,
   output logic              operand_valid,
   output logic [DW-1:0]     operand,
   output logic              illegal_mode
);
   generate
      if (MODE_W < 3) begin : g_bad_mode_w
         $error("MODE_W must hold the eight mode codes");
      end
      if (AW + MODE_W + RSEL_W > DW) begin : g_bad_fields
         $error("instruction fields do not fit in DW");
      end
      if (RSEL_W < 1) begin : g_bad_rsel
         $error("RSEL_W must be at least 1");
      end
   endgenerate

   mar_src_e          mar_sel_w;
   mbr_src_e          mbr_sel_w;
   logic [MODE_W-1:0] ir_mode_w;

   opf_ctrl #(.MODE_W(MODE_W)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .mem_ready     (mem_ready),
      .ir_mode       (ir_mode_w),
      .mem_rd        (mem_rd),
      .mar_ld        (mar_ld),
      .mar_sel       (mar_sel_w),
      .mbr_ld        (mbr_ld),
      .mbr_sel       (mbr_sel_w),
      .ir_ld         (ir_ld),
      .pc_inc        (pc_inc),
      .alu_add       (alu_add),
      .operand_valid (operand_valid),
      .illegal_mode  (illegal_mode)
   );

   opf_datapath #(
      .DW(DW), .AW(AW), .MODE_W(MODE_W), .RSEL_W(RSEL_W), .IMM_SIGNED(IMM_SIGNED)
   ) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_rdata (mem_rdata),
      .reg_rdata (reg_rdata),
      .mar_ld    (mar_ld),
      .mar_sel   (mar_sel_w),
      .mbr_ld    (mbr_ld),
      .mbr_sel   (mbr_sel_w),
      .ir_ld     (ir_ld),
      .pc_inc    (pc_inc),
      .pc_q      (pc),
      .mar_q     (mem_addr),
      .mbr_q     (operand),
      .ir_mode   (ir_mode_w),
      .ir_rsel   (reg_sel)
   );

   assign mar_sel = mar_sel_w;
endmodule

// File: rtl/opf_checker.sv
module opf_checker #(
   parameter int unsigned AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_rd,
   input logic          mem_ready,
   input logic [AW-1:0] mem_addr,
   input logic          mar_ld,
   input logic          mbr_ld,
   input logic          pc_inc,
   input logic          alu_add,
   input logic [AW-1:0] pc,
   input logic          operand_valid,
   input logic          illegal_mode
);
   // R9
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

   // R9
   mbr_on_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && mbr_ld) |-> mem_ready);

   // R2
   pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_inc |=> (pc == $past(pc) + 1'b1));

   // R10
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      operand_valid |=> !operand_valid);

   // R11
   illegal_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_mode |=> (!mem_rd && !operand_valid && !illegal_mode));

   // R7
   add_to_mar_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alu_add |-> (mar_ld && !mem_rd));
endmodule

bind opfetch_seq opf_checker #(.AW(AW)) u_opf_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .mem_rd        (mem_rd),
   .mem_ready     (mem_ready),
   .mem_addr      (mem_addr),
   .mar_ld        (mar_ld),
   .mbr_ld        (mbr_ld),
   .pc_inc        (pc_inc),
   .alu_add       (alu_add),
   .pc            (pc),
   .operand_valid (operand_valid),
   .illegal_mode  (illegal_mode)
);

// File: tb/test_opfetch_seq.sv
module test_opfetch_seq;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 14;

   typedef struct packed {
      logic [3:0] mode;
      logic [1:0] rsel;
      logic [7:0] addr;
      logic [3:0] lat;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{4'd0,  2'd0, 8'h5C, 4'd0},  // R3 immediate
      '{4'd1,  2'd2, 8'h00, 4'd1},  // R4 register
      '{4'd2,  2'd0, 8'h44, 4'd0},  // R5 direct
      '{4'd2,  2'd0, 8'h47, 4'd3},  // R9 direct with waits
      '{4'd3,  2'd1, 8'h00, 4'd0},  // R5 register indirect
      '{4'd4,  2'd0, 8'h48, 4'd0},  // R6 memory indirect
      '{4'd4,  2'd0, 8'h60, 4'd2},  // R6 memory indirect with waits
      '{4'd5,  2'd0, 8'h50, 4'd0},  // R7 relative
      '{4'd6,  2'd0, 8'h40, 4'd0},  // R8 base
      '{4'd7,  2'd3, 8'h44, 4'd1},  // R8 indexed, wraps
      '{4'd5,  2'd0, 8'hFC, 4'd0},  // R7 relative, wraps
      '{4'd9,  2'd0, 8'h00, 4'd0},  // R11 illegal
      '{4'd0,  2'd0, 8'hFF, 4'd2},  // R3 immediate top value
      '{4'd15, 2'd1, 8'h11, 4'd1}   // R11 illegal
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] mem_rdata;
   logic        mem_ready;
   logic [15:0] reg_rdata;
   logic [7:0]  mem_addr;
   logic        mem_rd;
   logic [1:0]  reg_sel;
   logic [2:0]  mar_sel;
   logic        mar_ld, mbr_ld, ir_ld, pc_inc, alu_add;
   logic [7:0]  pc;
   logic        operand_valid;
   logic [15:0] operand;
   logic        illegal_mode;

   logic [15:0] mem [256];
   logic [15:0] regs [4];
   logic [3:0]  lat_cfg = 4'd0;
   logic [3:0]  wait_cnt = 4'd0;
   int          rd_cnt = 0;
   int          checks = 0;
   int          failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   opfetch_seq i_opfetch_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .mem_rdata(mem_rdata),
      .mem_ready(mem_ready), .reg_rdata(reg_rdata), .mem_addr(mem_addr),
      .mem_rd(mem_rd), .reg_sel(reg_sel), .mar_sel(mar_sel), .mar_ld(mar_ld),
      .mbr_ld(mbr_ld), .ir_ld(ir_ld), .pc_inc(pc_inc), .alu_add(alu_add),
      .pc(pc), .operand_valid(operand_valid), .operand(operand),
      .illegal_mode(illegal_mode)
   );

   assign mem_rdata = mem[mem_addr];
   assign mem_ready = mem_rd && (wait_cnt >= lat_cfg);
   assign reg_rdata = regs[reg_sel];

   always @(posedge clk) begin
      if (mem_rd && !mem_ready) wait_cnt <= wait_cnt + 4'd1;
      else                      wait_cnt <= 4'd0;
      if (mem_rd && mem_ready)  rd_cnt <= rd_cnt + 1;
   end

   function automatic logic [15:0] fill(input int a);
      logic [7:0] b;
      b = 8'(a);
      return {b ^ 8'hC3, 8'(a * 7 + 3)};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] model(input logic [3:0] m, input logic [1:0] rs,
                                         input logic [7:0] a, input logic [7:0] pcn);
      logic [7:0] r8;
      r8 = regs[rs][7:0];
      case (m)
         4'd0: return {8'h00, a};
         4'd1: return regs[rs];
         4'd2: return mem[a];
         4'd3: return mem[r8];
         4'd4: return mem[mem[a][7:0]];
         4'd5: return mem[8'(pcn + a)];
         default: return mem[8'(r8 + a)];
      endcase
   endfunction

   task automatic run_one(input vec_t v, input bit extra_start, input string tag);
      logic [7:0]  pc0, pcn;
      logic [15:0] exp_op;
      int          base, nrd, exp_n, n, rd0;
      bit          got, ill;
      pc0 = pc;
      pcn = pc0 + 8'd1;
      mem[pc0] = {v.mode, v.rsel, 2'b00, v.addr};
      lat_cfg  = v.lat;
      exp_op   = model(v.mode, v.rsel, v.addr, pcn);
      case (v.mode)
         4'd0, 4'd1: begin base = 3; nrd = 1; end
         4'd4:       begin base = 6; nrd = 3; end
         4'd2, 4'd3, 4'd5, 4'd6, 4'd7: begin base = 4; nrd = 2; end
         default:    begin base = 2; nrd = 1; end
      endcase
      exp_n = base + int'(v.lat) * nrd;
      rd0 = rd_cnt;
      @(negedge clk) start = 1'b1;
      @(posedge clk);
      @(negedge clk) if (!extra_start) start = 1'b0;
      n = 0; got = 0; ill = 0;
      while (n < 200 && !got && !ill) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (n >= 2) start = 1'b0;
         got = operand_valid;
         ill = illegal_mode;
      end
      if (v.mode < 4'd8) begin
         chk(got, {tag, " operand_valid"}, 32'(got), 1);
         chk(operand == exp_op, {tag, " operand"}, 32'(operand), 32'(exp_op));
      end else begin
         chk(ill && !got, {tag, " illegal_mode"}, 32'(ill), 1);
      end
      chk(n == exp_n, {tag, " cycles"}, 32'(n), 32'(exp_n));
      @(negedge clk);
      chk(!operand_valid && !illegal_mode && !mem_rd, {tag, " back to idle"},
          32'({operand_valid, illegal_mode, mem_rd}), 0);
      chk(rd_cnt - rd0 == nrd, {tag, " read count"}, 32'(rd_cnt - rd0), 32'(nrd));
      chk(pc == pcn, {tag, " pc step R2"}, 32'(pc), 32'(pcn));
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = fill(i);
      regs[0] = 16'h1210;
      regs[1] = 16'h3455;
      regs[2] = 16'hBEEF;
      regs[3] = 16'h77F0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(pc == 8'd0, "R1 pc after reset", 32'(pc), 0);
      chk(!mem_rd && !operand_valid && !illegal_mode, "R1 outputs idle",
          32'({mem_rd, operand_valid, illegal_mode}), 0);
      repeat (4) @(negedge clk);
      chk(pc == 8'd0 && !mem_rd, "R1 stays idle without start", 32'(pc), 0);

      // vector table: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
      for (int k = 0; k < NVEC; k++) begin
         run_one(VECS[k], 1'b0, $sformatf("vec%0d", k));
      end

      // R12 start held during an instruction
      run_one('{4'd2, 2'd0, 8'h52, 4'd2}, 1'b1, "R12 start while busy");

      // R5 register indirect with waits after busy test
      run_one('{4'd3, 2'd3, 8'h00, 4'd3}, 1'b0, "R5 rind waits");

      // R1 reset in mid-sequence
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      chk(pc == 8'd0 && !mem_rd, "R1 reset mid-fetch", 32'(pc), 0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule